// File: doc/BRIEF.md
# General-purpose I/O port with single-pin event interrupt

The block is a general-purpose I/O port of `NPINS` pins (16 by default) behind a small register bus whose data width equals the pin count. Software controls an output data register and a per-pin direction register. It reads back a per-pin input register that samples the pins through a two-stage synchronizer. A control register carries a clock-enable bit. While that bit is clear, input sampling and event detection hold their values.

One pin at a time can be watched for an edge. A packed event-mode register holds three fields: an enable, the index of the watched pin, and the polarity of the edge. A matching edge on that pin sets a sticky GPIO bit in an interrupt status register. The same register also shows a keypad request bit. A mask register gates each source onto the single interrupt line. Reading the status register clears the GPIO bit. If a new event arrives in the cycle of that read, the event takes priority.

Register offsets on `bus_addr_i`: 0 output data, 1 input data (read-only), 2 direction, 3 control, 4 event mode, 5 interrupt status (read-only), 6 interrupt mask. Reads are combinational in the cycle that `bus_sel_i` is high with `bus_wr_i` low. Writes take effect at the clock edge. The asynchronous reset is released synchronously through two internal flops.

Top module: `gpio_evt_port`

## Requirements
- R1: After reset the direction register reads 0xFFFF (all pins inputs), `pin_oe_o` is 0, the output data register and `pin_o` are 0, the mask register reads 0x0003 (both sources masked), and `irq_o` is 0.
- R2: Direction bit i at 1 makes pin i an input and at 0 makes it an output: `pin_oe_o[i]` is the inverse of direction bit i, and `pin_o` equals the output data register. Both follow a write from the next cycle.
- R3: The input data register returns, for each pin set as an input, the synchronized pin level (visible three clocks after the pin changes). For each pin set as an output, it returns the driven output data bit.
- R4: Control bit 5 is the clock enable, and it is 0 after reset. While it is 0, the input data register does not change and no event is detected, whatever the pins do.
- R5: Event-mode bit 0 enables detection. Bits 4:1 give the watched pin index (0 to 15). Bit 5 selects the edge: 1 is rising, 0 is falling. Only a matching edge on the watched pin sets the GPIO status bit. Edges on other pins, and the opposite edge, do not set it.
- R6: Status bit 0 shows the keypad request input, and status bit 1 is the GPIO event. The GPIO bit stays set after the pin returns to its earlier level, and it clears when the status register is read.
- R7: Mask bit 0 masks the keypad source and mask bit 1 masks the GPIO source (1 = masked). `irq_o` is the OR of the status bits whose mask bit is 0.
- R8: When a status read and a new GPIO event fall in the same cycle, the GPIO status bit stays set.
- R9: With event-mode bit 0 clear, edges on the watched pin do not set the GPIO status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register offset |
| bus_wdata_i | input | NPINS | Write data |
| bus_rdata_o | output | NPINS | Read data (combinational) |
| pin_i | input | NPINS | Pin levels from the pads |
| pin_o | output | NPINS | Drive value per pin |
| pin_oe_o | output | NPINS | Output enable per pin (1 = drive) |
| kbd_req_i | input | 1 | Keypad interrupt request level |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench builds the block with its defaults: 16 pins and a two-stage synchronizer. With that size the event logic can be swept over every pin index with both edge polarities. Each case also checks a neighbouring pin and the wrong edge, so a wrong index field, polarity or field position shows up. Walking-bit patterns over direction and pin levels cover every bit of the read-back mux. One stimulus is timed cycle-exactly so that a status read lands on the same edge as a fresh event.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int unsigned REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_DOUT   = 3'd0;
  localparam logic [REG_AW-1:0] RA_DIN    = 3'd1;
  localparam logic [REG_AW-1:0] RA_DIR    = 3'd2;
  localparam logic [REG_AW-1:0] RA_CTRL   = 3'd3;
  localparam logic [REG_AW-1:0] RA_EVMODE = 3'd4;
  localparam logic [REG_AW-1:0] RA_ISTAT  = 3'd5;
  localparam logic [REG_AW-1:0] RA_IMASK  = 3'd6;

  localparam int unsigned CTRL_CLKEN_BIT = 5;
  localparam int unsigned NSRC     = 2;
  localparam int unsigned SRC_KBD  = 0;
  localparam int unsigned SRC_GPIO = 1;
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
  import gpio_evt_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      samp,
  input  logic [NSRC-1:0]   istat,
  output logic [W-1:0]      dout,
  output logic [W-1:0]      dir,
  output logic              clk_en,
  output logic              ev_en,
  output logic [IDX_W-1:0]  ev_idx,
  output logic              ev_pol,
  output logic [NSRC-1:0]   imask,
  output logic              rd_clr
);
  localparam int unsigned EVW = IDX_W + 2;

  logic [W-1:0]    dout_q, dout_d;
  logic [W-1:0]    dir_q, dir_d;
  logic            clken_q, clken_d;
  logic [EVW-1:0]  ev_q, ev_d;
  logic [NSRC-1:0] imask_q, imask_d;
  logic            wr_stb, rd_stb;

  assign wr_stb = bus_sel && bus_wr;
  assign rd_stb = bus_sel && !bus_wr;

  always_comb begin
    dout_d  = dout_q;
    dir_d   = dir_q;
    clken_d = clken_q;
    ev_d    = ev_q;
    imask_d = imask_q;
    if (wr_stb) begin
      case (bus_addr)
        RA_DOUT:   dout_d  = bus_wdata;
        RA_DIR:    dir_d   = bus_wdata;
        RA_CTRL:   clken_d = bus_wdata[CTRL_CLKEN_BIT];
        RA_EVMODE: ev_d    = bus_wdata[EVW-1:0];
        RA_IMASK:  imask_d = bus_wdata[NSRC-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      dir_q   <= '1;
      clken_q <= 1'b0;
      ev_q    <= '0;
      imask_q <= '1;
    end else begin
      dout_q  <= dout_d;
      dir_q   <= dir_d;
      clken_q <= clken_d;
      ev_q    <= ev_d;
      imask_q <= imask_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_stb) begin
      case (bus_addr)
        RA_DOUT:   bus_rdata = dout_q;
        RA_DIN:    bus_rdata = (dir_q & samp) | (~dir_q & dout_q);
        RA_DIR:    bus_rdata = dir_q;
        RA_CTRL:   bus_rdata[CTRL_CLKEN_BIT] = clken_q;
        RA_EVMODE: bus_rdata[EVW-1:0] = ev_q;
        RA_ISTAT:  bus_rdata[NSRC-1:0] = istat;
        RA_IMASK:  bus_rdata[NSRC-1:0] = imask_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign rd_clr = rd_stb && (bus_addr == RA_ISTAT);
  assign dout   = dout_q;
  assign dir    = dir_q;
  assign clk_en = clken_q;
  assign ev_en  = ev_q[0];
  assign ev_idx = ev_q[IDX_W:1];
  assign ev_pol = ev_q[IDX_W+1];
  assign imask  = imask_q;

  AST_EVMODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && bus_addr == RA_EVMODE) |=>
      (ev_en == $past(bus_wdata[0]) && ev_pol == $past(bus_wdata[IDX_W+1]))); // R5
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic [W-1:0]     sync_pins,
  input  logic             ev_en,
  input  logic [IDX_W-1:0] ev_idx,
  input  logic             ev_pol,
  input  logic             kbd_req,
  input  logic             rd_clr,
  input  logic [NSRC-1:0]  imask,
  output logic [W-1:0]     samp,
  output logic [NSRC-1:0]  istat,
  output logic             irq
);
  logic [W-1:0] samp_q, samp_d;
  logic         gstat_q, gstat_d;
  logic         kstat_q;
  logic         cur_lvl, old_lvl, evt;

  assign cur_lvl = sync_pins[ev_idx];
  assign old_lvl = samp_q[ev_idx];
  assign evt     = clk_en && ev_en && (cur_lvl != old_lvl) && (cur_lvl == ev_pol);

  always_comb begin
    samp_d = clk_en ? sync_pins : samp_q;
    if (evt)         gstat_d = 1'b1;
    else if (rd_clr) gstat_d = 1'b0;
    else             gstat_d = gstat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= '0;
      gstat_q <= 1'b0;
      kstat_q <= 1'b0;
    end else begin
      samp_q  <= samp_d;
      gstat_q <= gstat_d;
      kstat_q <= kbd_req;
    end
  end

  always_comb begin
    istat           = '0;
    istat[SRC_KBD]  = kstat_q;
    istat[SRC_GPIO] = gstat_q;
  end

  assign samp = samp_q;
  assign irq  = |(istat & ~imask);

  AST_FROZEN_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(samp_q)); // R4
  AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (gstat_q && !rd_clr) |=> gstat_q); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !evt) |=> !gstat_q); // R6
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && rd_clr) |=> gstat_q); // R8
  AST_NO_EVT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_en && !gstat_q) |=> !gstat_q); // R9
endmodule

// File: rtl/gpio_evt_port.sv
module gpio_evt_port
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NPINS       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [NPINS-1:0]  bus_wdata_i,
  output logic [NPINS-1:0]  bus_rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  input  logic              kbd_req_i,
  output logic              irq_o
);
  localparam int unsigned IDX_W = $clog2(NPINS);

  logic [1:0]       rst_pipe_q;
  logic             rst_n;
  logic [NPINS-1:0] sync_pins, samp, dout, dir;
  logic [NSRC-1:0]  istat, imask;
  logic             clk_en, ev_en, ev_pol, rd_clr;
  logic [IDX_W-1:0] ev_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  gpio_evt_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_i), .rst_n(rst_n), .d(pin_i), .q(sync_pins)
  );

  gpio_evt_regs #(.W(NPINS), .IDX_W(IDX_W)) u_regs (
    .clk(clk_i), .rst_n(rst_n),
    .bus_sel(bus_sel_i), .bus_wr(bus_wr_i), .bus_addr(bus_addr_i),
    .bus_wdata(bus_wdata_i), .bus_rdata(bus_rdata_o),
    .samp(samp), .istat(istat),
    .dout(dout), .dir(dir), .clk_en(clk_en),
    .ev_en(ev_en), .ev_idx(ev_idx), .ev_pol(ev_pol),
    .imask(imask), .rd_clr(rd_clr)
  );

  gpio_evt_detect #(.W(NPINS), .IDX_W(IDX_W)) u_detect (
    .clk(clk_i), .rst_n(rst_n), .clk_en(clk_en),
    .sync_pins(sync_pins), .ev_en(ev_en), .ev_idx(ev_idx), .ev_pol(ev_pol),
    .kbd_req(kbd_req_i), .rd_clr(rd_clr), .imask(imask),
    .samp(samp), .istat(istat), .irq(irq_o)
  );

  assign pin_o    = dout;
  assign pin_oe_o = ~dir;

  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_sel_i && bus_wr_i && bus_addr_i == RA_DIR) |=> (pin_oe_o == ~$past(bus_wdata_i))); // R2
  AST_ALL_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    (&imask) |-> !irq_o); // R7
endmodule

// File: tb/tb_gpio_evt_port.sv
module tb_gpio_evt_port;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel, wr;
  logic [2:0]    addr;
  logic [N-1:0]  wdata, rdata, pins, pout, poe;
  logic          kbd, irq;
  int            checks = 0;
  int            fails  = 0;
  logic [N-1:0]  rv;

  always #2 clk = ~clk;

  gpio_evt_port dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_i(pins), .pin_o(pout), .pin_oe_o(poe), .kbd_req_i(kbd), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    pins = '0; kbd = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    rreg(3'd2, rv); chk("R1 dir", rv, 16'hFFFF);
    rreg(3'd0, rv); chk("R1 dout", rv, 16'h0000);
    rreg(3'd6, rv); chk("R1 mask", rv, 16'h0003);
    chk("R1 oe", poe, 16'h0000);
    chk("R1 pout", pout, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'd0);

    // R2 direction and drive, walking patterns
    for (int i = 0; i < N; i++) begin
      wreg(3'd2, ~(16'h1 << i));
      chk("R2 oe", poe, 16'h1 << i);
      wreg(3'd0, 16'hA5A5 ^ (16'h1 << i));
      chk("R2 pout", pout, 16'hA5A5 ^ (16'h1 << i));
    end

    // R3 input read-back
    wreg(3'd3, 16'h0020);
    wreg(3'd2, 16'hFFFF);
    for (int i = 0; i < N; i++) begin
      pins = 16'h1 << i;
      idle(4);
      rreg(3'd1, rv); chk("R3 din walk", rv, 16'h1 << i);
    end
    wreg(3'd2, 16'h00FF);
    wreg(3'd0, 16'hA5A5);
    pins = 16'h3C3C;
    idle(4);
    rreg(3'd1, rv); chk("R3 din mixed", rv, (16'h00FF & 16'h3C3C) | (16'hFF00 & 16'hA5A5));
    wreg(3'd2, 16'hFFFF);

    // R7 unmask both, R6 keypad level
    wreg(3'd6, 16'h0000);
    pins = 16'h0000;
    idle(4);
    rreg(3'd5, rv);
    kbd = 1'b1; idle(2);
    rreg(3'd5, rv); chk("R6 kbd set", rv & 16'h3, 16'h0001);
    rreg(3'd5, rv); chk("R6 kbd held", rv & 16'h3, 16'h0001);
    chk("R7 kbd irq", {15'd0, irq}, 16'd1);
    wreg(3'd6, 16'h0001);
    chk("R7 kbd masked", {15'd0, irq}, 16'd0);
    wreg(3'd6, 16'h0000);
    kbd = 1'b0; idle(2);
    rreg(3'd5, rv); chk("R6 kbd clear", rv & 16'h3, 16'h0000);

    // R5 exhaustive pin/edge sweep, with R6 clear on read
    for (int pol = 0; pol < 2; pol++) begin
      for (int p = 0; p < N; p++) begin
        logic [N-1:0] base;
        int q;
        base = (pol == 1) ? 16'h0000 : 16'hFFFF;
        q = (p + 1) % N;
        pins = base; idle(4);
        wreg(3'd4, 16'h1 | (16'(p) << 1) | (16'(pol) << 5));
        idle(1);
        rreg(3'd5, rv);
        pins = base ^ (16'h1 << q); idle(4);
        pins = base; idle(4);
        rreg(3'd5, rv); chk("R5 other pin ignored", rv & 16'h2, 16'h0);
        pins = base ^ (16'h1 << p); idle(4);
        chk("R7 gpio irq", {15'd0, irq}, 16'd1);
        rreg(3'd5, rv); chk("R5 edge seen", rv & 16'h3, 16'h2);
        rreg(3'd5, rv); chk("R6 read cleared", rv & 16'h3, 16'h0);
        pins = base; idle(4);
        rreg(3'd5, rv); chk("R5 wrong edge ignored", rv & 16'h2, 16'h0);
      end
    end

    // R6 sticky and R7 gpio mask (rising on pin 3)
    pins = 16'h0000; idle(4);
    wreg(3'd4, 16'h1 | (16'd3 << 1) | 16'h20);
    rreg(3'd5, rv);
    pins = 16'h0008; idle(4);
    pins = 16'h0000; idle(4);
    wreg(3'd6, 16'h0002);
    chk("R7 gpio masked", {15'd0, irq}, 16'd0);
    wreg(3'd6, 16'h0000);
    chk("R7 gpio unmasked", {15'd0, irq}, 16'd1);
    rreg(3'd5, rv); chk("R6 sticky", rv & 16'h2, 16'h2);

    // R8 read and event in the same cycle
    pins = 16'h0008;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = 3'd5;
    #1 rv = rdata;
    @(negedge clk);
    sel = 1'b0;
    chk("R8 read before event", rv & 16'h2, 16'h0);
    rreg(3'd5, rv); chk("R8 event wins", rv & 16'h2, 16'h2);
    pins = 16'h0000; idle(4);
    rreg(3'd5, rv);

    // R9 event mode disabled
    wreg(3'd4, (16'd3 << 1) | 16'h20);
    pins = 16'h0008; idle(4);
    pins = 16'h0000; idle(4);
    rreg(3'd5, rv); chk("R9 disabled", rv & 16'h2, 16'h0);

    // R4 clock enable cleared freezes sampling and events
    wreg(3'd4, 16'h1 | (16'd3 << 1) | 16'h20);
    rreg(3'd1, rv); chk("R4 din before", rv, 16'h0000);
    wreg(3'd3, 16'h0000);
    pins = 16'hFFFF; idle(4);
    rreg(3'd1, rv); chk("R4 din frozen", rv, 16'h0000);
    rreg(3'd5, rv); chk("R4 no event", rv & 16'h2, 16'h0);
    pins = 16'h0000; idle(4);
    wreg(3'd3, 16'h0020);
    rreg(3'd3, rv); chk("R4 ctrl readback", rv, 16'h0020);
    pins = 16'h0008; idle(4);
    rreg(3'd1, rv); chk("R4 din resumes", rv, 16'h0008);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule